// File: doc/BRIEF.md
# Serial Flag-Offset Register Loader

This block fills the two threshold registers that a FIFO's partial-flag comparators use: the almost-empty offset and the almost-full offset. Both values arrive as one continuous bitstream on a single data pin. The write clock strobes each bit in, one bit per edge. The stream can be paused at any bit boundary and resumed later. During a pause, the surrounding FIFO can accept ordinary writes, and the block raises a pass-through indication for as long as that is allowed.

The offset width follows the FIFO address width `AW`, so one complete load is `2*AW` bits. The comparators must ignore the two offsets until the block reports them valid. Validity is removed as soon as the first bit of a new load is taken. It returns only after the last bit of the whole set has been taken, and then with a fixed two-edge delay. A single offset cannot be rewritten on its own.

Top module: `ofs_serial_loader`

## Requirements
- R1: While reset is applied, and for the edges that follow until a bit is loaded, both offsets read 0 and both valid outputs read 0.
- R2: A bit on `ser_bit` is taken on a rising `wclk` edge only when `load_n` and `ser_en_n` are both 0. With `load_n`=1 and `ser_en_n`=0, the offsets do not change, whatever `ser_bit` does.
- R3: The first bit of a set becomes bit 0 of `empty_ofs`, and bit `AW` of the set becomes bit 0 of `full_ofs`. The last bit (index `2*AW-1`) becomes the top bit of `full_ofs`. The most recently taken bit always appears at the top bit of `full_ofs`.
- R4: With `load_n`=0 and `ser_en_n`=1, no bit is taken, the position in the set is kept, and the valid outputs keep their value.
- R5: A set loaded with pauses of either kind between bits gives the same offsets as a set loaded without pauses. Loading resumes at the next bit position.
- R6: `wr_pass` is 1 exactly when `load_n` and `ser_en_n` are both 1. While `wr_pass` is 1, the offsets do not change.
- R7: The edge that takes any bit drives both valid outputs to 0 after that edge.
- R8: `ae_valid` and `af_valid` both rise on the second rising edge after the edge that takes the final bit of a set, and are 0 after the first.
- R9: After a partial load (fewer than `2*AW` bits), both valid outputs stay 0 for any length of pause. Once set, they stay 1 for as long as no bit is taken.
- R10: After a complete set, the next bit taken is bit 0 of a new set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously inside |
| load_n | input | 1 | Active-low offset-load select |
| ser_en_n | input | 1 | Active-low serial enable |
| ser_bit | input | 1 | Serial offset data bit |
| empty_ofs | output | AW | Assembled almost-empty offset |
| full_ofs | output | AW | Assembled almost-full offset |
| ae_valid | output | 1 | Almost-empty offset usable by the comparator |
| af_valid | output | 1 | Almost-full offset usable by the comparator |
| wr_pass | output | 1 | Ordinary FIFO writes may be passed through |

## Verification
Offsets and the drop of validity are registered results. They are due directly after the edge that takes a bit, and the bench samples them at the following falling edge. The rise of validity is due on the second edge after the completing edge. The bench therefore samples it after the first edge, expecting 0, and after the second, expecting 1. `wr_pass` is a combinational result of the two enables, so it is sampled one time unit after the inputs change, before any edge. The bench drives every input at a falling edge, which puts each stimulus in front of exactly one rising edge.

// File: rtl/ofsld_pkg.sv
package ofsld_pkg;

  // Number of serial bits in one complete offset set
  function automatic int unsigned set_len(input int unsigned aw);
    return 2 * aw;
  endfunction

  // Decoded state of the two enables
  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,  // both enables high: FIFO writes allowed
    MODE_HOLD  = 2'd1,  // exactly one enable high: loading suspended
    MODE_SHIFT = 2'd2   // both enables low: take one bit
  } ld_mode_e;

endpackage

// File: rtl/ofsld_rst_sync.sv
module ofsld_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ofsld_seq.sv
module ofsld_seq
  import ofsld_pkg::*;
#(
  parameter int unsigned AW = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_n,
  input  logic ser_en_n,
  output logic shift_en,
  output logic set_done,
  output logic wr_pass
);
  localparam int unsigned TOTAL = set_len(AW);
  localparam int unsigned CNT_W = $clog2(TOTAL);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

  ld_mode_e         mode;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    unique case ({load_n, ser_en_n})
      2'b00:   mode = MODE_SHIFT;
      2'b11:   mode = MODE_PASS;
      default: mode = MODE_HOLD;
    endcase
  end

  assign shift_en = (mode == MODE_SHIFT);
  assign wr_pass  = (mode == MODE_PASS);
  assign set_done = shift_en && (cnt_q == LAST);
  assign cnt_en   = shift_en;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = set_done ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ofsld_shreg.sv
module ofsld_shreg #(
  parameter int unsigned W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  logic [W-1:0] sr_q, sr_d;

  // New bit enters at the top; after W shifts the first bit sits at bit 0
  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {din, sr_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= sr_d;
  end

  assign q = sr_q;
endmodule

// File: rtl/ofsld_valid.sv
module ofsld_valid (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic set_done,
  output logic valid
);
  logic pend1_q, pend2_q, valid_q;
  logic pend1_d, pend2_d, valid_d;

  always_comb begin
    if (shift_en) begin
      pend1_d = set_done;
      pend2_d = 1'b0;
      valid_d = 1'b0;
    end else begin
      pend1_d = 1'b0;
      pend2_d = pend1_q;
      valid_d = valid_q | pend2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend1_q <= 1'b0;
      pend2_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      pend1_q <= pend1_d;
      pend2_q <= pend2_d;
      valid_q <= valid_d;
    end
  end

  assign valid = valid_q;
endmodule

// File: rtl/ofs_serial_loader.sv
module ofs_serial_loader
  import ofsld_pkg::*;
#(
  parameter int unsigned AW = 14
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          load_n,
  input  logic          ser_en_n,
  input  logic          ser_bit,
  output logic [AW-1:0] empty_ofs,
  output logic [AW-1:0] full_ofs,
  output logic          ae_valid,
  output logic          af_valid,
  output logic          wr_pass
);
  localparam int unsigned TOTAL = set_len(AW);

  logic             rst_q_n;
  logic             shift_en;
  logic             set_done;
  logic             valid;
  logic [TOTAL-1:0] set_bits;

  ofsld_rst_sync i_rst (
    .clk        (wclk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_q_n)
  );

  ofsld_seq #(.AW(AW)) i_seq (
    .clk      (wclk),
    .rst_n    (rst_q_n),
    .load_n   (load_n),
    .ser_en_n (ser_en_n),
    .shift_en (shift_en),
    .set_done (set_done),
    .wr_pass  (wr_pass)
  );

  ofsld_shreg #(.W(TOTAL)) i_shreg (
    .clk      (wclk),
    .rst_n    (rst_q_n),
    .shift_en (shift_en),
    .din      (ser_bit),
    .q        (set_bits)
  );

  ofsld_valid i_valid (
    .clk      (wclk),
    .rst_n    (rst_q_n),
    .shift_en (shift_en),
    .set_done (set_done),
    .valid    (valid)
  );

  assign empty_ofs = set_bits[AW-1:0];
  assign full_ofs  = set_bits[TOTAL-1:AW];
  assign ae_valid  = valid;
  assign af_valid  = valid;
endmodule

// File: rtl/ofsld_chk.sv
module ofsld_chk #(
  parameter int unsigned AW = 14
) (
  input logic          wclk,
  input logic          rst_q_n,
  input logic          load_n,
  input logic          ser_en_n,
  input logic          ser_bit,
  input logic [AW-1:0] empty_ofs,
  input logic [AW-1:0] full_ofs,
  input logic          ae_valid,
  input logic          af_valid,
  input logic          wr_pass
);
  logic cap;
  assign cap = !load_n && !ser_en_n;

  p_newbit_r3: assert property (@(posedge wclk) disable iff (!rst_q_n)
    cap |=> full_ofs[AW-1] == $past(ser_bit));

  p_hold_r4: assert property (@(posedge wclk) disable iff (!rst_q_n)
    (!load_n && ser_en_n) |=> $stable(empty_ofs) && $stable(full_ofs));

  p_pass_stable_r6: assert property (@(posedge wclk) disable iff (!rst_q_n)
    wr_pass |=> $stable(empty_ofs) && $stable(full_ofs));

  p_pass_enables_r6: assert property (@(posedge wclk) disable iff (!rst_q_n)
    wr_pass |-> (load_n && ser_en_n));

  p_cap_drop_r7: assert property (@(posedge wclk) disable iff (!rst_q_n)
    cap |=> !ae_valid && !af_valid);

  p_rise_quiet_r8: assert property (@(posedge wclk) disable iff (!rst_q_n)
    $rose(af_valid) |-> !$past(cap) && !$past(cap, 2));

  p_valid_keep_r9: assert property (@(posedge wclk) disable iff (!rst_q_n)
    (ae_valid && !cap) |=> ae_valid && af_valid);
endmodule

bind ofs_serial_loader ofsld_chk #(.AW(AW)) i_chk (
  .wclk      (wclk),
  .rst_q_n   (rst_q_n),
  .load_n    (load_n),
  .ser_en_n  (ser_en_n),
  .ser_bit   (ser_bit),
  .empty_ofs (empty_ofs),
  .full_ofs  (full_ofs),
  .ae_valid  (ae_valid),
  .af_valid  (af_valid),
  .wr_pass   (wr_pass)
);

// File: tb/test_ofs_serial_loader.sv
module test_ofs_serial_loader;
  localparam int AW    = 14;
  localparam int TOTAL = 2 * AW;

  logic          wclk = 1'b0;
  logic          rst_n, load_n, ser_en_n, ser_bit;
  logic [AW-1:0] empty_ofs, full_ofs;
  logic          ae_valid, af_valid, wr_pass;
  int            n_chk = 0, n_fail = 0;
  bit            finished = 0;

  always #2.5 wclk = ~wclk;

  ofs_serial_loader #(.AW(AW)) i_ofs_serial_loader (
    .wclk(wclk), .rst_n(rst_n), .load_n(load_n), .ser_en_n(ser_en_n),
    .ser_bit(ser_bit), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .ae_valid(ae_valid), .af_valid(af_valid), .wr_pass(wr_pass));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // One input pattern held across exactly one rising edge
  task automatic drive(input logic l, input logic s, input logic b);
    load_n = l; ser_en_n = s; ser_bit = b;
    @(negedge wclk);
  endtask

  function automatic logic bit_of(input logic [AW-1:0] e, input logic [AW-1:0] f, input int idx);
    return (idx < AW) ? e[idx] : f[idx-AW];
  endfunction

  task automatic send_range(input logic [AW-1:0] e, input logic [AW-1:0] f, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) drive(1'b0, 1'b0, bit_of(e, f, i));
  endtask

  // Called right after the completing edge: checks the two-edge rise and the values
  task automatic finish_check(input logic [AW-1:0] e, input logic [AW-1:0] f, input string req);
    chk(!ae_valid && !af_valid, "R8 low after completing edge", {ae_valid, af_valid}, 0);
    drive(1'b1, 1'b1, 1'b0);
    chk(!ae_valid && !af_valid, "R8 low after first edge", {ae_valid, af_valid}, 0);
    drive(1'b1, 1'b1, 1'b0);
    chk(ae_valid && af_valid, "R8 high after second edge", {ae_valid, af_valid}, 3);
    chk(empty_ofs == e, {req, " empty offset"}, empty_ofs, e);
    chk(full_ofs == f, {req, " full offset"}, full_ofs, f);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; load_n = 1'b1; ser_en_n = 1'b1; ser_bit = 1'b0;
    repeat (4) @(negedge wclk);
    chk(empty_ofs == 0 && full_ofs == 0, "R1 offsets in reset", {empty_ofs, full_ofs}, 0);
    chk(!ae_valid && !af_valid, "R1 valid in reset", {ae_valid, af_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge wclk);
    chk(!ae_valid && empty_ofs == 0, "R1 after release", {ae_valid, empty_ofs}, 0);
    #1 chk(wr_pass == 1'b1, "R6 pass when both high", wr_pass, 1);
  endtask

  task automatic t_full_load(input logic [AW-1:0] e, input logic [AW-1:0] f, input string req);
    drive(1'b0, 1'b0, bit_of(e, f, 0));
    chk(!ae_valid && !af_valid, "R7 drop on first bit", {ae_valid, af_valid}, 0);
    send_range(e, f, 1, TOTAL - 1);
    chk(full_ofs[AW-1] == f[AW-1], "R3 last bit at top", full_ofs[AW-1], f[AW-1]);
    finish_check(e, f, req);
  endtask

  task automatic t_hold();
    logic [AW-1:0] e0 = empty_ofs, f0 = full_ofs;
    for (int i = 0; i < 6; i++) begin
      load_n = 1'b0; ser_en_n = 1'b1; ser_bit = i[0];
      #1 chk(wr_pass == 1'b0, "R6 no pass while load selected", wr_pass, 0);
      @(negedge wclk);
    end
    chk(empty_ofs == e0 && full_ofs == f0, "R4 offsets kept", {empty_ofs, full_ofs}, {e0, f0});
    chk(ae_valid && af_valid, "R4 valid kept", {ae_valid, af_valid}, 3);
  endtask

  task automatic t_serial_only();
    logic [AW-1:0] e0 = empty_ofs, f0 = full_ofs;
    for (int i = 0; i < 5; i++) begin
      load_n = 1'b1; ser_en_n = 1'b0; ser_bit = ~i[0];
      #1 chk(wr_pass == 1'b0, "R6 no pass with serial enable", wr_pass, 0);
      @(negedge wclk);
    end
    chk(empty_ofs == e0 && full_ofs == f0, "R2 no capture with load high", {empty_ofs, full_ofs}, {e0, f0});
  endtask

  task automatic t_paused(input logic [AW-1:0] e, input logic [AW-1:0] f);
    send_range(e, f, 0, 4);
    chk(!ae_valid, "R7 invalid during load", ae_valid, 0);
    repeat (3) drive(1'b0, 1'b1, 1'b1);
    send_range(e, f, 5, 12);
    for (int i = 0; i < 4; i++) begin
      load_n = 1'b1; ser_en_n = 1'b1; ser_bit = i[0];
      #1 chk(wr_pass == 1'b1, "R6 pass during pause", wr_pass, 1);
      @(negedge wclk);
    end
    chk(!ae_valid && !af_valid, "R9 invalid while paused", {ae_valid, af_valid}, 0);
    repeat (2) drive(1'b1, 1'b0, 1'b1);
    send_range(e, f, 13, TOTAL - 1);
    finish_check(e, f, "R5 paused load");
  endtask

  task automatic t_partial(input logic [AW-1:0] e, input logic [AW-1:0] f);
    send_range(e, f, 0, 9);
    repeat (20) drive(1'b1, 1'b1, 1'b0);
    chk(!ae_valid && !af_valid, "R9 partial set stays invalid", {ae_valid, af_valid}, 0);
    send_range(e, f, 10, TOTAL - 1);
    finish_check(e, f, "R9 completed after long pause");
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    t_reset();
    t_full_load(14'h2A5C, 14'h1F03, "R3 first set");
    t_full_load(14'h0001, 14'h2000, "R10 second set");
    t_hold();
    t_serial_only();
    t_full_load(14'h3FFF, 14'h0000, "R3 extremes");
    t_paused(14'h1234, 14'h2DCB);
    t_partial(14'h0F0F, 14'h30C3);
    summary();
  end
endmodule